// File: doc/BRIEF.md
# Dual-Compare Prescaled Timer

This block is a single 16-bit general-purpose timer for a system that supplies a slow reference rate as a one-cycle enable pulse (`ref_en`) inside the main clock domain. A power-of-two prescaler divides those pulses, and the counter advances on each prescaled tick while counting is enabled. Two compare registers are checked against the count on every tick. A match sets a sticky event flag. A match on the second compare also wraps the count back to zero, so compare 2 sets the period of a periodic timer.

Software reaches four 16-bit registers through a single-cycle write port and a combinational read port: setup, counter, compare 1 and compare 2. The setup register is configured once. The first write after reset fixes the prescale exponent and the two event-mode fields, and marks the timer configured. Later writes can only start or stop counting and clear flags. A small state machine tracks this with three states: `ST_UNCONF` (never configured), `ST_STOPPED` (configured, not counting) and `ST_RUNNING` (configured and counting). The interrupt output is asserted for any set flag whose event mode is non-zero.

Top module: `dcpt_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The counter advances once per 2^scale cycles on which `ref_en` is high, where scale is setup bits [3:0]. Cycles with `ref_en` low do not advance the prescaler.
- R3: While counting is disabled the prescaler is held at zero and the counter holds its value. After counting is enabled, the first count therefore takes a full 2^scale reference pulses.
- R4: The setup layout is: [3:0] scale, [7:6] compare-1 mode, [9:8] compare-2 mode, [12] configured (read-only), [13] compare-1 flag, [14] compare-2 flag, [15] count enable. Other bits read zero. The first setup write loads scale and both modes and sets the configured bit. Later writes leave scale and modes unchanged.
- R5: The counter register can be written at any time. The write takes priority over a tick in the same cycle and restarts the prescaler.
- R6: On a tick where the count equals compare 1, flag 1 is set and counting continues.
- R7: On a tick where the count equals compare 2, flag 2 is set and the counter goes to zero instead of incrementing.
- R8: Writing 1 to setup bit 13 or 14 clears that flag, and writing 0 leaves it unchanged. A flag set in the same cycle as a clear stays set.
- R9: A single setup write can set count enable and clear a flag in the same operation.
- R10: `irq` is high exactly when some flag is set and its mode field is non-zero. It falls in the cycle after the flag is cleared. A flag whose mode is 0 is still readable but does not raise `irq`.
- R11: The register addresses are 0 setup, 1 counter, 2 compare 1 and 3 compare 2. `rd_data` follows `rd_addr` combinationally.
- R12: The state machine moves from `ST_UNCONF` to `ST_RUNNING` or `ST_STOPPED` on the first setup write, according to bit 15. It moves from `ST_STOPPED` to `ST_RUNNING` on a setup write with bit 15 set, and from `ST_RUNNING` to `ST_STOPPED` on a setup write with bit 15 clear. Only reset returns it to `ST_UNCONF`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One pulse per reference clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The count path is driven with a divide-by-4 prescale over run lengths that end just before and just after a tick boundary. These runs separate a correct prescale and hold-at-stop from an off-by-one or a prescaler that keeps its phase across a stop. Divide-by-1 runs long enough to wrap at compare 2 check the reload-to-zero against plain incrementing. They also show that a mode-0 compare raises its flag without the interrupt. A second configuration write with different fields, writes of zero to the flag bits, and a combined enable-and-clear write separate the lock and write-one-to-clear rules from a plain register. A run with `ref_en` held low confirms that counting depends on reference pulses rather than main clock cycles.

// File: rtl/dcpt_pkg.sv
package dcpt_pkg;
    localparam int CNT_W   = 16;
    localparam int SCALE_W = 4;
    localparam int MODE_W  = 2;
    localparam int ADDR_W  = 2;
    localparam int NUM_CMP = 2;

    // setup register field positions
    localparam int SCALE_LSB = 0;
    localparam int M1_LSB    = 6;
    localparam int M2_LSB    = 8;
    localparam int DONE_BIT  = 12;
    localparam int F1_BIT    = 13;
    localparam int F2_BIT    = 14;
    localparam int EN_BIT    = 15;

    typedef enum logic [ADDR_W-1:0] {
        REG_SETUP = 2'd0,
        REG_COUNT = 2'd1,
        REG_CMP1  = 2'd2,
        REG_CMP2  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_UNCONF  = 2'd0,
        ST_STOPPED = 2'd1,
        ST_RUNNING = 2'd2
    } run_state_e;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [MODE_W-1:0]  mode1;
        logic [MODE_W-1:0]  mode2;
    } cfg_t;
endpackage

// File: rtl/dcpt_ctrl_fsm.sv
module dcpt_ctrl_fsm
    import dcpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       setup_wr,
    input  logic       wr_run,
    input  cfg_t       wr_cfg,
    output cfg_t       cfg_q,
    output logic       count_en,
    output logic       setup_done,
    output run_state_e state_o
);
    run_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_UNCONF;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCONF: begin
                if (setup_wr) state_d = wr_run ? ST_RUNNING : ST_STOPPED;
            end
            ST_STOPPED: begin
                if (setup_wr && wr_run) state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (setup_wr && !wr_run) state_d = ST_STOPPED;
            end
            default: state_d = ST_UNCONF;
        endcase
    end

    // configuration captured only on the first setup write
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (setup_wr && state_q == ST_UNCONF) begin
            cfg_q <= wr_cfg;
        end
    end

    // outputs
    always_comb begin
        count_en   = 1'b0;
        setup_done = 1'b0;
        unique case (state_q)
            ST_UNCONF:  begin count_en = 1'b0; setup_done = 1'b0; end
            ST_STOPPED: begin count_en = 1'b0; setup_done = 1'b1; end
            ST_RUNNING: begin count_en = 1'b1; setup_done = 1'b1; end
            default:    begin count_en = 1'b0; setup_done = 1'b0; end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/dcpt_prescaler.sv
module dcpt_prescaler #(
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               ref_en,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    localparam int PRE_W = (1 << SCALE_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_w;
    logic [PRE_W:0]   mask_w;
    logic [PRE_W-1:0] mask;

    assign one_w  = {{PRE_W{1'b0}}, 1'b1};
    assign mask_w = (one_w << scale) - one_w;
    assign mask   = mask_w[PRE_W-1:0];

    assign tick = ref_en && !hold && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || hold) pre_q <= '0;
        else if (ref_en) pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/dcpt_count_cmp.sv
module dcpt_count_cmp #(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          cnt_wr,
    input  logic [CNT_W-1:0]              wdata,
    input  logic [NUM_CMP-1:0]            cmp_wr,
    input  logic [NUM_CMP-1:0]            flag_clr,
    output logic [CNT_W-1:0]              cnt_q,
    output logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q,
    output logic [NUM_CMP-1:0]            flag_q
);
    localparam int WRAP_IDX = NUM_CMP - 1;

    logic [NUM_CMP-1:0] hit;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst)            cmp_q[g] <= '0;
            else if (cmp_wr[g]) cmp_q[g] <= wdata;
        end

        assign hit[g] = tick && (cnt_q == cmp_q[g]);

        // a new event beats a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst)              flag_q[g] <= 1'b0;
            else if (hit[g])      flag_q[g] <= 1'b1;
            else if (flag_clr[g]) flag_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_wr)        cnt_q <= wdata;
        else if (hit[WRAP_IDX]) cnt_q <= '0;
        else if (tick)          cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dcpt_timer.sv
module dcpt_timer
    import dcpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic setup_wr, cnt_wr;
    logic [NUM_CMP-1:0] cmp_wr, flag_clr, flag_q, mode_on;
    cfg_t wr_cfg, cfg_q;
    logic count_en, setup_done, tick;
    run_state_e state;
    logic [CNT_W-1:0] cnt_q;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] setup_rd;

    // write decode
    assign setup_wr    = wr_en && (reg_addr_e'(wr_addr) == REG_SETUP);
    assign cnt_wr      = wr_en && (reg_addr_e'(wr_addr) == REG_COUNT);
    assign cmp_wr[0]   = wr_en && (reg_addr_e'(wr_addr) == REG_CMP1);
    assign cmp_wr[1]   = wr_en && (reg_addr_e'(wr_addr) == REG_CMP2);
    assign flag_clr[0] = setup_wr && wr_data[F1_BIT];
    assign flag_clr[1] = setup_wr && wr_data[F2_BIT];

    assign wr_cfg.scale = wr_data[SCALE_LSB +: SCALE_W];
    assign wr_cfg.mode1 = wr_data[M1_LSB +: MODE_W];
    assign wr_cfg.mode2 = wr_data[M2_LSB +: MODE_W];

    dcpt_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .setup_wr   (setup_wr),
        .wr_run     (wr_data[EN_BIT]),
        .wr_cfg     (wr_cfg),
        .cfg_q      (cfg_q),
        .count_en   (count_en),
        .setup_done (setup_done),
        .state_o    (state)
    );

    dcpt_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .hold   (!count_en || cnt_wr),
        .ref_en (ref_en),
        .scale  (cfg_q.scale),
        .tick   (tick)
    );

    dcpt_count_cmp #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cc (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .wdata    (wr_data),
        .cmp_wr   (cmp_wr),
        .flag_clr (flag_clr),
        .cnt_q    (cnt_q),
        .cmp_q    (cmp_q),
        .flag_q   (flag_q)
    );

    // setup read image
    always_comb begin
        setup_rd                          = '0;
        setup_rd[SCALE_LSB +: SCALE_W]    = cfg_q.scale;
        setup_rd[M1_LSB +: MODE_W]        = cfg_q.mode1;
        setup_rd[M2_LSB +: MODE_W]        = cfg_q.mode2;
        setup_rd[DONE_BIT]                = setup_done;
        setup_rd[F1_BIT]                  = flag_q[0];
        setup_rd[F2_BIT]                  = flag_q[1];
        setup_rd[EN_BIT]                  = count_en;
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            REG_SETUP: rd_data = setup_rd;
            REG_COUNT: rd_data = cnt_q;
            REG_CMP1:  rd_data = cmp_q[0];
            REG_CMP2:  rd_data = cmp_q[1];
            default:   rd_data = '0;
        endcase
    end

    assign mode_on[0] = |cfg_q.mode1;
    assign mode_on[1] = |cfg_q.mode2;
    assign irq        = |(flag_q & mode_on);
endmodule

// File: rtl/dcpt_timer_chk.sv
module dcpt_timer_chk
    import dcpt_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          setup_wr,
    input logic                          cnt_wr,
    input logic [CNT_W-1:0]              wr_data,
    input logic                          tick,
    input logic                          count_en,
    input logic                          setup_done,
    input cfg_t                          cfg_q,
    input logic [CNT_W-1:0]              cnt_q,
    input logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q,
    input logic [NUM_CMP-1:0]            flag_q,
    input logic                          irq
);
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !cnt_wr) |=> $stable(cnt_q)); // R3

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        setup_done |=> $stable(cfg_q)); // R4

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        setup_wr |=> setup_done); // R12

    AST_CMP2_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt_q == cmp_q[1]) |=> (cnt_q == '0 && flag_q[1])); // R7

    AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q[0] && !(setup_wr && wr_data[F1_BIT])) |=> flag_q[0]); // R8

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (setup_wr && wr_data[F1_BIT] && wr_data[F2_BIT] && !tick) |=> !irq); // R10
endmodule

bind dcpt_timer dcpt_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .setup_wr   (setup_wr),
    .cnt_wr     (cnt_wr),
    .wr_data    (wr_data),
    .tick       (tick),
    .count_en   (count_en),
    .setup_done (setup_done),
    .cfg_q      (cfg_q),
    .cnt_q      (cnt_q),
    .cmp_q      (cmp_q),
    .flag_q     (flag_q),
    .irq        (irq)
);

// File: tb/test_dcpt_timer.sv
module test_dcpt_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit busy = 1'b0;

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [1:0]  addr;
        logic [15:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    dcpt_timer i_dcpt_timer (
        .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                busy = 1'b1;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                #1;
                checks++;
                if (it.is_irq) begin
                    if (irq !== it.exp[0]) begin
                        errors++;
                        $display("FAIL %s irq actual %0b expected %0b", it.tag, irq, it.exp[0]);
                    end
                end else if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s reg%0d actual %h expected %h", it.tag, it.addr, rd_data, it.exp);
                end
                busy = 1'b0;
            end
        end
    end

    task automatic settle();
        while (sb_q.size() != 0 || busy) @(negedge clk);
    endtask

    task automatic exp_reg(string tag, logic [1:0] a, logic [15:0] e);
        item_t it;
        it.tag = tag; it.is_irq = 1'b0; it.addr = a; it.exp = e;
        sb_q.push_back(it);
        settle();
    endtask

    task automatic exp_irq(string tag, bit e);
        item_t it;
        it.tag = tag; it.is_irq = 1'b1; it.addr = 2'd0; it.exp = {15'd0, e};
        sb_q.push_back(it);
        settle();
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // start write, then stop write: k clock edges see counting enabled
    task automatic run_for(logic [15:0] start_val, int k);
        wr(2'd0, start_val);
        repeat (k - 2) @(negedge clk);
        wr(2'd0, 16'h0000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        exp_reg("R1 setup", 2'd0, 16'h0000);
        exp_reg("R1 counter", 2'd1, 16'h0000);
        exp_reg("R1 cmp2", 2'd3, 16'h0000);
        exp_irq("R1 irq", 1'b0);

        // R11 compare registers by address
        wr(2'd2, 16'h0005);
        wr(2'd3, 16'hFFFF);
        exp_reg("R11 cmp1 readback", 2'd2, 16'h0005);
        exp_reg("R11 cmp2 readback", 2'd3, 16'hFFFF);

        // R2 R4 R12: first write scale 2, mode1 3, enable; 15 edges -> 3 ticks
        run_for(16'h80C2, 15);
        exp_reg("R2 counter after 15 edges div4", 2'd1, 16'd3);
        exp_reg("R4 R12 setup stopped image", 2'd0, 16'h10C2);

        // R3 stopped counter holds
        repeat (10) @(negedge clk);
        exp_reg("R3 counter holds while stopped", 2'd1, 16'd3);
        // R3 restart: 3 edges give no tick when prescaler restarted
        run_for(16'h8000, 3);
        exp_reg("R3 first count needs full period", 2'd1, 16'd3);

        // R5 R6: load counter 5, one tick matches compare 1
        wr(2'd1, 16'd5);
        exp_reg("R5 counter write", 2'd1, 16'd5);
        run_for(16'h8000, 4);
        exp_reg("R6 counter continues past cmp1", 2'd1, 16'd6);
        exp_reg("R6 flag1 set", 2'd0, 16'h30C2);
        exp_irq("R10 irq with flag1 mode3", 1'b1);

        // R4 lock: new fields ignored, R8 zero in flag bits keeps flag
        wr(2'd0, 16'h0300);
        exp_reg("R4 R8 lock keeps fields and flag", 2'd0, 16'h30C2);
        exp_irq("R8 irq still high", 1'b1);

        // R8 R10 write one to clear
        wr(2'd0, 16'h2000);
        exp_reg("R8 flag1 cleared", 2'd0, 16'h10C2);
        exp_irq("R10 irq low after clear", 1'b0);

        // second configuration: scale 0, mode1 0, mode2 3
        do_reset();
        exp_reg("R1 R12 setup after second reset", 2'd0, 16'h0000);
        wr(2'd2, 16'd1);
        wr(2'd3, 16'd3);
        run_for(16'h8300, 10);
        exp_reg("R7 counter wraps at cmp2", 2'd1, 16'd2);
        exp_reg("R7 both flags", 2'd0, 16'h7300);
        wr(2'd0, 16'h4000);
        exp_reg("R8 clear only flag2", 2'd0, 16'h3300);
        exp_irq("R10 mode0 flag gives no irq", 1'b0);

        // R9 enable plus clear of flag1
        run_for(16'hA000, 2);
        exp_reg("R7 wrap to zero", 2'd1, 16'd0);
        exp_reg("R9 flag1 cleared flag2 set", 2'd0, 16'h5300);
        exp_irq("R10 irq from flag2", 1'b1);
        run_for(16'hC000, 2);
        exp_reg("R9 counted after combined write", 2'd1, 16'd2);
        exp_reg("R9 flag2 cleared flag1 set", 2'd0, 16'h3300);
        exp_irq("R9 irq low", 1'b0);

        // R2 no reference pulses, no count
        ref_en = 1'b0;
        run_for(16'h8000, 6);
        ref_en = 1'b1;
        exp_reg("R2 no count without ref_en", 2'd1, 16'd2);

        // R5 counter write of zero
        wr(2'd1, 16'd0);
        exp_reg("R5 counter restarted", 2'd1, 16'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule